// File: doc/BRIEF.md
# Integer Video Scaler

This block resizes a raster video stream by whole-number ratios. Each axis is set on its own: a mode bit chooses enlarge or shrink, and a factor gives the ratio. Enlarging repeats each pixel (horizontal) or each line (vertical) as many times as the factor says. Shrinking by N keeps the first pixel or line of every group of N and discards the rest. The block does no filtering and no fractional ratios.

Pixels arrive on a ready/valid stream that also carries start-of-frame and end-of-frame markers, and they pass through a synchronous input FIFO. The vertical stage then takes one input line at a time. When the line is kept, it goes into a dual-port line buffer and is replayed once, or as many times as the enlarge factor gives. The horizontal stage repeats or drops pixels from that replayed line and writes them into an output FIFO. The output stream carries fresh frame markers, placed on the first and last pixels of the scaled frame. The width, height, factors and modes are static configuration inputs, and they change only while the block is idle.

Top module: `int_scaler`

## Requirements
- R1: With factor 1 on both axes, the output frame equals the input frame pixel for pixel, in raster order.
- R2: When the vertical mode bit is 1 (enlarge) and the factor is F (1 to 4), every input line appears F times in a row at the output.
- R3: When the horizontal mode bit is 1 (enlarge) and the factor is F (1 to 4), every input pixel appears F times in a row within its line.
- R4: When the vertical mode bit is 0 (shrink) and the factor is N (1 to 16), only input rows whose index is a multiple of N reach the output, counting from row 0.
- R5: When the horizontal mode bit is 0 (shrink) and the factor is N (1 to 16), only input columns whose index is a multiple of N reach the output, counting from column 0.
- R6: The two axes scale independently, so any mix of enlarge and shrink modes and factors gives the product of the two separate mappings.
- R7: out_sof is 1 on exactly the first output pixel of a scaled frame, and out_eof is 1 on exactly the last one. The scaled width is W*F when enlarging and ceil(W/N) when shrinking. The height follows the same rule.
- R8: in_ready falls once the internal storage is full. While out_valid is 1 and out_ready is 0, out_data, out_sof and out_eof hold steady. Back-pressure neither loses nor duplicates any pixel.
- R9: An input pixel with in_sof set is taken as row 0, column 0. A partly received line that comes before it produces no output.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | DIM_W | Input line length in pixels (1 to LINE_MAX) |
| cfg_height | input | DIM_W | Input frame height in lines |
| cfg_hfactor | input | 5 | Horizontal factor |
| cfg_hup | input | 1 | Horizontal mode: 1 enlarge, 0 shrink |
| cfg_vfactor | input | 5 | Vertical factor |
| cfg_vup | input | 1 | Vertical mode: 1 enlarge, 0 shrink |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input FIFO can accept a pixel |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eof | input | 1 | Input pixel is the last of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | First pixel of the scaled frame |
| out_eof | output | 1 | Last pixel of the scaled frame |

## Verification
The pass-through frame shows that the datapath itself does not corrupt, reorder or re-mark pixels. Each single-axis case, with line enlarge, pixel enlarge, row shrink and column shrink, isolates one mapping, so a wrong keep phase or repeat count shows up as a specific misplaced pixel. Mixed cases use odd sizes. One shrinks by 16 on a 7-pixel line, leaving a single column per line. Another shrinks to two rows of 33 while enlarging the width. Together they check the tail tests that place out_eof, and a 1x1 frame enlarged 4x4 has its first and last markers far apart. Random and total output stalls check that in_ready falls and that no pixel is lost. An aborted partial line before a fresh start-of-frame checks that position realigns.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int FAC_W = 5;

  typedef enum logic [1:0] {
    VS_FILL,
    VS_PREP,
    VS_EMIT
  } vstate_e;
endpackage

// File: rtl/scaler_fifo.sv
module scaler_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic push, pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // R8: occupancy never exceeds the storage
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/scaler_vstage.sv
module scaler_vstage
  import scaler_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int DIM_W    = 13,
  parameter int LINE_MAX = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfg_w,
  input  logic [DIM_W-1:0] cfg_h,
  input  logic [FAC_W-1:0] cfg_fac,
  input  logic             cfg_up,
  input  logic             i_valid,
  input  logic [PIX_W-1:0] i_data,
  input  logic             i_sof,
  input  logic             i_eof,
  output logic             i_take,
  output logic             o_valid,
  output logic [PIX_W-1:0] o_data,
  output logic             o_lfirst,
  output logic             o_llast,
  output logic             o_ffirst,
  output logic             o_flast,
  input  logic             o_ready
);
  localparam int AW = $clog2(LINE_MAX);

  logic [PIX_W-1:0] lbuf [LINE_MAX];
  logic [PIX_W-1:0] q;
  vstate_e st;
  logic [DIM_W-1:0] col, row, ecol, erow, len;
  logic [FAC_W-1:0] ph, eph, rep, reps;
  logic [AW-1:0] rcol, rd_addr;
  logic line_row0, line_last;
  logic keep, row_end, frame_end, adv, at_end;

  always_comb begin
    ecol      = i_sof ? '0 : col;
    erow      = i_sof ? '0 : row;
    eph       = i_sof ? '0 : ph;
    keep      = cfg_up || (eph == '0);
    row_end   = i_eof || (ecol == cfg_w - 1'b1);
    frame_end = i_eof || (row_end && (erow == cfg_h - 1'b1));
    i_take    = (st == VS_FILL) && i_valid;
    adv       = (st == VS_EMIT) && o_ready;
    at_end    = (DIM_W'(rcol) == len - 1'b1);
    rd_addr   = adv ? (at_end ? '0 : rcol + 1'b1) : rcol;
  end

  // dual-port line buffer: write port fed by the fill, registered read port
  always_ff @(posedge clk) begin
    if (i_take && keep) lbuf[ecol[AW-1:0]] <= i_data;
    q <= lbuf[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= VS_FILL;
      col       <= '0;
      row       <= '0;
      ph        <= '0;
      rcol      <= '0;
      rep       <= '0;
      reps      <= FAC_W'(1);
      len       <= DIM_W'(1);
      line_row0 <= 1'b0;
      line_last <= 1'b0;
    end else begin
      case (st)
        VS_FILL: if (i_take) begin
          if (row_end) begin
            col <= '0;
            if (frame_end) begin
              row <= '0;
              ph  <= '0;
            end else begin
              row <= erow + 1'b1;
              ph  <= (cfg_up || eph == cfg_fac - 1'b1) ? '0 : eph + 1'b1;
            end
            if (keep) begin
              st        <= VS_PREP;
              len       <= ecol + 1'b1;
              reps      <= cfg_up ? cfg_fac : FAC_W'(1);
              rep       <= '0;
              rcol      <= '0;
              line_row0 <= (erow == '0);
              line_last <= frame_end ||
                           (!cfg_up && (cfg_h - 1'b1 - erow) < DIM_W'(cfg_fac));
            end
          end else begin
            col <= ecol + 1'b1;
            row <= erow;
            ph  <= eph;
          end
        end
        VS_PREP: st <= VS_EMIT;
        VS_EMIT: if (o_ready) begin
          if (at_end) begin
            rcol <= '0;
            if (rep == reps - 1'b1) begin
              st  <= VS_FILL;
              rep <= '0;
            end else begin
              rep <= rep + 1'b1;
            end
          end else begin
            rcol <= rcol + 1'b1;
          end
        end
        default: st <= VS_FILL;
      endcase
    end
  end

  assign o_valid  = (st == VS_EMIT);
  assign o_data   = q;
  assign o_lfirst = (rcol == '0);
  assign o_llast  = at_end;
  assign o_ffirst = line_row0 && (rep == '0);
  assign o_flast  = line_last && (rep == reps - 1'b1);

  // R8: a replayed pixel waits unchanged while the horizontal stage stalls
  a_r8_vstage_hold: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
  // R4: a kept line always fits the line buffer
  a_r4_line_fits: assert property (@(posedge clk) disable iff (rst)
    (i_take && keep) |-> (ecol < DIM_W'(LINE_MAX)));
endmodule

// File: rtl/scaler_hstage.sv
module scaler_hstage
  import scaler_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIM_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfg_w,
  input  logic [FAC_W-1:0] cfg_fac,
  input  logic             cfg_up,
  input  logic             i_valid,
  input  logic [PIX_W-1:0] i_data,
  input  logic             i_lfirst,
  input  logic             i_llast,
  input  logic             i_ffirst,
  input  logic             i_flast,
  output logic             i_ready,
  output logic             w_en,
  output logic [PIX_W-1:0] w_pix,
  output logic             w_sof,
  output logic             w_eof,
  input  logic             w_full
);
  logic [DIM_W-1:0] hcol, ecol;
  logic [FAC_W-1:0] hph, eph, hrep;
  logic last_copy, keep, first_out, last_out;

  always_comb begin
    ecol      = i_lfirst ? '0 : hcol;
    eph       = i_lfirst ? '0 : hph;
    last_copy = !cfg_up || (hrep == cfg_fac - 1'b1);
    keep      = cfg_up || (eph == '0);
    first_out = i_lfirst && (!cfg_up || hrep == '0);
    last_out  = cfg_up ? (i_llast && last_copy)
                       : (i_llast || (cfg_w - 1'b1 - ecol) < DIM_W'(cfg_fac));
    i_ready   = !w_full && last_copy;
    w_en      = i_valid && !w_full && keep;
    w_pix     = i_data;
    w_sof     = i_ffirst && first_out;
    w_eof     = i_flast && last_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcol <= '0;
      hph  <= '0;
      hrep <= '0;
    end else if (i_valid && !w_full) begin
      if (last_copy) begin
        hcol <= ecol + 1'b1;
        hph  <= (cfg_up || eph == cfg_fac - 1'b1) ? '0 : eph + 1'b1;
        hrep <= '0;
      end else begin
        hrep <= hrep + 1'b1;
      end
    end
  end

  // R3: while copies are still being written the source pixel stays put
  a_r3_copy_hold: assert property (@(posedge clk) disable iff (rst)
    (i_valid && !i_ready && !w_full) |=> (i_valid && $stable(i_data)));
endmodule

// File: rtl/int_scaler.sv
module int_scaler
  import scaler_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int DIM_W     = 13,
  parameter int LINE_MAX  = 256,
  parameter int IN_DEPTH  = 16,
  parameter int OUT_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic [FAC_W-1:0] cfg_hfactor,
  input  logic             cfg_hup,
  input  logic [FAC_W-1:0] cfg_vfactor,
  input  logic             cfg_vup,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eof
);
  localparam int EW = PIX_W + 2;

  logic in_full, in_empty, v_take;
  logic [EW-1:0] in_q;
  logic v_valid, v_lfirst, v_llast, v_ffirst, v_flast, h_ready;
  logic [PIX_W-1:0] v_data, w_pix;
  logic w_en, w_sof, w_eof, out_full, out_empty;
  logic [EW-1:0] out_q;

  assign in_ready = !in_full;

  scaler_fifo #(.WIDTH(EW), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk(clk), .rst(rst),
    .wr_en(in_valid), .wr_data({in_sof, in_eof, in_data}), .full(in_full),
    .rd_en(v_take), .rd_data(in_q), .empty(in_empty)
  );

  scaler_vstage #(.PIX_W(PIX_W), .DIM_W(DIM_W), .LINE_MAX(LINE_MAX)) u_vstage (
    .clk(clk), .rst(rst),
    .cfg_w(cfg_width), .cfg_h(cfg_height), .cfg_fac(cfg_vfactor), .cfg_up(cfg_vup),
    .i_valid(!in_empty), .i_data(in_q[PIX_W-1:0]), .i_sof(in_q[EW-1]),
    .i_eof(in_q[EW-2]), .i_take(v_take),
    .o_valid(v_valid), .o_data(v_data), .o_lfirst(v_lfirst), .o_llast(v_llast),
    .o_ffirst(v_ffirst), .o_flast(v_flast), .o_ready(h_ready)
  );

  scaler_hstage #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u_hstage (
    .clk(clk), .rst(rst),
    .cfg_w(cfg_width), .cfg_fac(cfg_hfactor), .cfg_up(cfg_hup),
    .i_valid(v_valid), .i_data(v_data), .i_lfirst(v_lfirst), .i_llast(v_llast),
    .i_ffirst(v_ffirst), .i_flast(v_flast), .i_ready(h_ready),
    .w_en(w_en), .w_pix(w_pix), .w_sof(w_sof), .w_eof(w_eof), .w_full(out_full)
  );

  scaler_fifo #(.WIDTH(EW), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk(clk), .rst(rst),
    .wr_en(w_en), .wr_data({w_sof, w_eof, w_pix}), .full(out_full),
    .rd_en(out_ready), .rd_data(out_q), .empty(out_empty)
  );

  assign out_valid = !out_empty;
  assign out_data  = out_q[PIX_W-1:0];
  assign out_sof   = out_q[EW-1];
  assign out_eof   = out_q[EW-2];

  // R8: a stalled output pixel and its markers do not change
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));
endmodule

// File: tb/int_scaler_bench.sv
module int_scaler_bench;
  localparam int PIX_W = 8;
  localparam int DIM_W = 13;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic [DIM_W-1:0] cfg_width = 13'd1, cfg_height = 13'd1;
  logic [4:0] cfg_hfactor = 5'd1, cfg_vfactor = 5'd1;
  logic cfg_hup = 1'b1, cfg_vup = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eof;
  logic out_ready = 1'b0;
  logic [PIX_W-1:0] out_data;

  int_scaler u_int_scaler (
    .clk(clk), .rst(rst),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_hfactor(cfg_hfactor), .cfg_hup(cfg_hup),
    .cfg_vfactor(cfg_vfactor), .cfg_vup(cfg_vup),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R10";
  bit stall_rand = 1'b0;
  bit hold_out = 1'b0;
  bit sent = 1'b0;
  logic [9:0] expq[$];

  function automatic logic [7:0] pix(int r, int c, int s);
    return 8'((r * 7 + c * 3 + s) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      out_ready = hold_out ? 1'b0 : (stall_rand ? (($urandom % 3) != 0) : 1'b1);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, cur_req, "unexpected output pixel",
                int'({out_sof, out_eof, out_data}), -1);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check({out_sof, out_eof, out_data} == e, cur_req, "pixel {sof,eof,data}",
                int'({out_sof, out_eof, out_data}), int'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic build(int w, int h, bit vup, int vf, bit hup, int hf, int s);
    int rows[$];
    int cols[$];
    for (int r = 0; r < h; r++)
      if (vup) begin
        for (int k = 0; k < vf; k++) rows.push_back(r);
      end else if (r % vf == 0) rows.push_back(r);
    for (int c = 0; c < w; c++)
      if (hup) begin
        for (int k = 0; k < hf; k++) cols.push_back(c);
      end else if (c % hf == 0) cols.push_back(c);
    foreach (rows[i])
      foreach (cols[j])
        expq.push_back({(i == 0 && j == 0),
                        (i == rows.size() - 1 && j == cols.size() - 1),
                        pix(rows[i], cols[j], s)});
  endtask

  task automatic configure(int w, int h, bit vup, int vf, bit hup, int hf);
    @(negedge clk);
    cfg_width = DIM_W'(w);
    cfg_height = DIM_W'(h);
    cfg_vup = vup;
    cfg_vfactor = 5'(vf);
    cfg_hup = hup;
    cfg_hfactor = 5'(hf);
  endtask

  task automatic send(int w, int h, int s, bit gaps);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        if (gaps && (c % 3 == 1)) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data = pix(r, c, s);
        in_sof = (r == 0 && c == 0);
        in_eof = (r == h - 1 && c == w - 1);
        while (!in_ready) @(negedge clk);
      end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_eof = 1'b0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (expq.size() != 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    check(expq.size() == 0, req, "frame complete, pixels still expected",
          expq.size(), 0);
  endtask

  task automatic run(string req, int w, int h, bit vup, int vf, bit hup, int hf,
                     int s, bit gaps);
    cur_req = req;
    configure(w, h, vup, vf, hup, hf);
    build(w, h, vup, vf, hup, hf, s);
    send(w, h, s, gaps);
    drain(req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state at the ports
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

    run("R1", 8, 6, 1'b1, 1, 1'b1, 1, 3, 1'b0);
    run("R2", 5, 4, 1'b1, 3, 1'b1, 1, 11, 1'b1);
    run("R3", 6, 3, 1'b1, 1, 1'b1, 4, 20, 1'b0);
    run("R4", 10, 9, 1'b0, 4, 1'b1, 1, 5, 1'b0);
    run("R5", 13, 5, 1'b1, 1, 1'b0, 3, 9, 1'b1);
    run("R6", 7, 7, 1'b1, 2, 1'b0, 16, 40, 1'b0);
    stall_rand = 1'b1;
    run("R6", 33, 17, 1'b0, 16, 1'b1, 2, 61, 1'b1);
    run("R8", 10, 9, 1'b0, 4, 1'b1, 1, 77, 1'b0);
    run("R7", 1, 1, 1'b1, 4, 1'b1, 4, 90, 1'b0);
    run("R7", 9, 5, 1'b0, 2, 1'b0, 2, 14, 1'b1);
    stall_rand = 1'b0;

    // R9: a partial line then a fresh start of frame
    cur_req = "R9";
    configure(4, 2, 1'b1, 1, 1'b1, 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'hEE;
      in_sof = (k == 0);
      in_eof = 1'b0;
      while (!in_ready) @(negedge clk);
    end
    build(4, 2, 1'b1, 1, 1'b1, 1, 33);
    send(4, 2, 33, 1'b0);
    drain("R9");

    // R8: full output stall fills the storage and lowers in_ready
    cur_req = "R8";
    configure(16, 16, 1'b1, 1, 1'b1, 1);
    build(16, 16, 1'b1, 1, 1'b1, 1, 50);
    hold_out = 1'b1;
    sent = 1'b0;
    fork
      begin
        send(16, 16, 50, 1'b0);
        sent = 1'b1;
      end
    join_none
    repeat (800) @(negedge clk);
    check(in_ready == 1'b0, "R8", "in_ready under total output stall", in_ready, 0);
    hold_out = 1'b0;
    wait (sent);
    drain("R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule